// File: doc/BRIEF.md
# Folded Single-Port SRAM with Column Multiplexing

This block is a synchronous single-port memory of 2048 words of 16 bits. The words are not kept in a flat array. They are folded into a physical array of 256 rows, each 128 columns wide. The upper part of the address picks a row. A two-stage decoder turns it into a single active row line: small predecoders first, then narrow AND gates. The lower three address bits choose one of eight column groups. Sixteen 8:1 multiplexers then take the addressed word out of the selected 128-bit row.

A write reads the selected row and replaces only the 16 columns of the addressed word. The merged row is then written back, so the other seven words sharing that row keep their contents. A read captures the multiplexed word in an output register. Each cycle carries at most one operation, a read or a write. The output register keeps its value on any cycle without a read.

Top module: `sram_fold`

## Requirements
- R1: Each of the 2048 addresses stores its own 16-bit word. A read returns the data of the most recent write to that address.
- R2: Address bits [10:3] select the row and bits [2:0] select the column group k. Bit i of a word sits in physical column i*8+k. Addresses that differ only in bits [2:0] therefore share a row but hold independent words.
- R3: The row decoder asserts exactly one of its 256 row lines for every address. It is built from 2-bit predecoders (one-of-four) feeding AND gates of at most four inputs. This covers the extreme rows 0 and 255.
- R4: A write changes only the 16 addressed columns of the selected row. Back-to-back writes to different column groups of one row all survive, and the other seven words of that row stay unchanged.
- R5: When `en`=1 and `wrEn`=0 at a rising clock edge, `rdData` shows the addressed word from that edge on. It is stable when sampled before the next edge.
- R6: `rdData` holds its previous value across any edge without a read. This includes idle cycles (`en`=0) and write cycles.
- R7: At most one operation happens per cycle. `en`=1 with `wrEn`=1 writes `wrData`, `en`=1 with `wrEn`=0 reads, and `en`=0 changes neither the array nor `rdData`.
- R8: While `rst_n` is low, `rdData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| en | input | 1 | Access enable for this cycle |
| wrEn | input | 1 | 1 = write, 0 = read when `en` is high |
| addr | input | 11 | Word address: [10:3] row, [2:0] column group |
| wrData | input | 16 | Word to be written |
| rdData | output | 16 | Registered read data |

## Verification
Two things can land in the same cycle. The first is the write merge into a row. The second is the output register holding the word read earlier. A write cycle must update the row while leaving `rdData` untouched. The bench provokes this by reading a word and then writing all eight column groups of that same row on consecutive cycles. It checks `rdData` on every one of those clocks against a behavioural model, expecting the word read earlier. A final sweep of reads over the row then confirms that each merged word landed in its own column group without overwriting its neighbours.

// File: rtl/sram_fold_pkg.sv
package sram_fold_pkg;

  // Strobes from control to datapath; at most one is high per cycle.
  typedef struct packed {
    logic rowWrite;
    logic rowRead;
  } sramStrobes_t;

endpackage

// File: rtl/sram_fold_ctrl.sv
module sram_fold_ctrl
  import sram_fold_pkg::*;
(
  input  logic         en,
  input  logic         wrEn,
  output sramStrobes_t strobes
);

  // R7: one operation per cycle, direction chosen by wrEn
  always_comb begin
    strobes          = '0;
    strobes.rowWrite = en & wrEn;
    strobes.rowRead  = en & ~wrEn;
  end

endmodule

// File: rtl/sram_fold_rowdec.sv
module sram_fold_rowdec #(
  parameter int ROW_BITS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ROW_BITS-1:0]       rowAddr,
  output logic [(1<<ROW_BITS)-1:0]  rowSel
);

  localparam int ROWS = 1 << ROW_BITS;
  localparam int NGRP = ROW_BITS / 2;

  // First stage: one-of-four predecode per 2-bit address group.
  logic [3:0] pre [NGRP];

  always_comb begin
    for (int g = 0; g < NGRP; g++) begin
      pre[g] = 4'b0001 << rowAddr[2*g +: 2];
    end
  end

  // Second stage: one AND of NGRP predecode lines per row.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic hit;
    always_comb begin
      hit = 1'b1;
      for (int g = 0; g < NGRP; g++) begin
        hit = hit & pre[g][(r >> (2*g)) & 3];
      end
    end
    assign rowSel[r] = hit;
  end

  // R3
  one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rowSel) == 1);

endmodule

// File: rtl/sram_fold_datapath.sv
module sram_fold_datapath
  import sram_fold_pkg::*;
#(
  parameter int ROW_BITS = 8,
  parameter int COL_BITS = 3,
  parameter int DATA_W   = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  sramStrobes_t              strobes,
  input  logic [(1<<ROW_BITS)-1:0]  rowSel,
  input  logic [COL_BITS-1:0]       colSel,
  input  logic [DATA_W-1:0]         wrData,
  output logic [DATA_W-1:0]         rdData
);

  localparam int ROWS = 1 << ROW_BITS;
  localparam int MUXW = 1 << COL_BITS;
  localparam int COLS = DATA_W * MUXW;

  logic [COLS-1:0]   memRows [ROWS];
  logic [COLS-1:0]   rowData;
  logic [COLS-1:0]   mergedRow;
  logic [DATA_W-1:0] colOut;

  // Wired-OR read of the single enabled row.
  always_comb begin
    rowData = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (rowSel[r]) rowData = rowData | memRows[r];
    end
  end

  // Per-bit MUXW:1 column multiplexers; bit i of group k at column i*MUXW+k.
  for (genvar i = 0; i < DATA_W; i++) begin : g_colmux
    assign colOut[i] = rowData[i*MUXW + int'(colSel)];
  end

  // Write merge: only the addressed word's columns take new data.
  always_comb begin
    mergedRow = rowData;
    for (int i = 0; i < DATA_W; i++) begin
      mergedRow[i*MUXW + int'(colSel)] = wrData[i];
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (strobes.rowWrite && rowSel[r]) memRows[r] <= mergedRow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData <= '0;
    end else if (strobes.rowRead) begin
      rdData <= colOut;
    end
  end

  // R7
  single_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.rowWrite && strobes.rowRead));

  // R4
  merge_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.rowWrite |-> $countones(mergedRow ^ rowData) <= DATA_W);

  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(strobes.rowRead)) |-> $stable(rdData));

endmodule

// File: rtl/sram_fold.sv
module sram_fold
  import sram_fold_pkg::*;
#(
  parameter int ROW_BITS = 8,
  parameter int COL_BITS = 3,
  parameter int DATA_W   = 16,
  localparam int ADDR_W  = ROW_BITS + COL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  sramStrobes_t              strobes;
  logic [(1<<ROW_BITS)-1:0]  rowSel;
  logic [ROW_BITS-1:0]       rowAddr;
  logic [COL_BITS-1:0]       colSel;

  // R2: row field above the column-group field
  assign rowAddr = addr[ADDR_W-1:COL_BITS];
  assign colSel  = addr[COL_BITS-1:0];

  sram_fold_ctrl i_ctrl (
    .en      (en),
    .wrEn    (wrEn),
    .strobes (strobes)
  );

  sram_fold_rowdec #(.ROW_BITS(ROW_BITS)) i_rowdec (
    .clk     (clk),
    .rst_n   (rst_n),
    .rowAddr (rowAddr),
    .rowSel  (rowSel)
  );

  sram_fold_datapath #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS),
    .DATA_W   (DATA_W)
  ) i_datapath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .rowSel  (rowSel),
    .colSel  (colSel),
    .wrData  (wrData),
    .rdData  (rdData)
  );

endmodule

// File: tb/test_sram_fold.sv
`timescale 1ns/1ps
module test_sram_fold;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        wrEn = 1'b0;
  logic [10:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;

  int          nRun  = 0;
  int          nFail = 0;
  bit          done  = 1'b0;
  logic [15:0] model [2048];
  logic [15:0] expRd = '0;

  always #4 clk = ~clk;

  sram_fold i_sram_fold (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData)
  );

  task automatic check(input string tag);
    nRun++;
    if (rdData !== expRd) begin
      nFail++;
      $display("FAIL %s: rdData=%h expected=%h (addr=%0d)", tag, rdData, expRd, addr);
    end
  endtask

  // One cycle: drive at negedge, model updates at posedge, compare after.
  task automatic op(input bit e, input bit w, input int a, input logic [15:0] d,
                    input string tag);
    @(negedge clk);
    en = e; wrEn = w; addr = 11'(a); wrData = d;
    @(posedge clk);
    if (e && w)  model[a] = d;
    if (e && !w) expRd = model[a];
    @(negedge clk);
    #1 check(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    expRd = '0;
    check("R8 reset");
    rst_n = 1'b1;

    // Fill every address (R1); rdData must stay put on writes (R6).
    for (int a = 0; a < 2048; a++) op(1, 1, a, 16'(a * 16'h9E37 + 16'h1234), "R6 write hold");
    for (int a = 0; a < 2048; a += 97) op(1, 0, a, '0, "R1 read");

    // Extreme rows and column groups (R3, R2).
    op(1, 1, 0,    16'hA5A5, "R3 write row0");
    op(1, 1, 2047, 16'h5A5A, "R3 write row255");
    op(1, 0, 0,    '0,       "R3 read row0");
    op(1, 0, 2047, '0,       "R3 read row255");
    op(1, 0, 7,    '0,       "R2 neighbour of row0");
    op(1, 0, 2040, '0,       "R2 neighbour of row255");

    // Read a word, then write all column groups of that row back to back (R4, R6).
    op(1, 0, 5*8+3, '0, "R5 read before merge");
    for (int k = 0; k < 8; k++) op(1, 1, 5*8+k, 16'hF000 | 16'(k * 16'h0111), "R6 hold during merge");
    for (int k = 0; k < 8; k++) op(1, 0, 5*8+k, '0, "R4 merged word");

    // Single column group rewrite leaves neighbours (R4, R2).
    op(1, 1, 9*8+4, 16'hFFFF, "R4 write one group");
    for (int k = 0; k < 8; k++) op(1, 0, 9*8+k, '0, "R4 neighbour intact");

    // Idle cycles: no change; disabled write ignored (R7, R6).
    op(1, 0, 100, '0, "R5 read");
    op(0, 1, 100, 16'hDEAD, "R7 idle with wrEn");
    op(0, 0, 200, '0, "R6 idle hold");
    op(1, 0, 100, '0, "R7 no write when en low");

    // Random mix compared every clock (R1, R5, R6, R7).
    for (int n = 0; n < 4000; n++) begin
      int a = int'($urandom_range(0, 2047));
      int s = int'($urandom_range(0, 3));
      op(s != 3, s == 0, a, 16'($urandom), "R1 random mix");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule